// File: doc/BRIEF.md
# Translation Entry Table Command Engine

This block owns the table of address translation entries for one I/O window and carries out the commands that software issues against it. A command names a window, an I/O bus address, a value (an entry, or the address of a list of entries in memory) and a page count. The engine checks the command, turns the bus address into a table index, and then reads or writes entries one page at a time. A status is posted when the command ends. The same table is read by the address translator through a separate read port.

There are four commands: write one entry, read one entry, fill a run of consecutive pages with one value, and copy a run of entries from a list in memory. Every entry the engine writes produces an invalidation notice, so that cached translations for that page can be dropped. The notice goes out over a valid/ready handshake, and the engine waits for the consumer. Multi-page commands stop at the first entry that fails. Entries written before that point stay in the table.

Top module: `xlt_cmd_engine`

## Requirements
- R1: A command whose 64-bit window identifier has any nonzero bit in [63:32], or whose bits [31:0] differ from the parameter WINDOW_ID, ends with status 1 (parameter error). It writes no entry and sends no notice.
- R2: Before indexing, the bus address has its low PAGE_SHIFT bits cleared. The entry index is (aligned address − BUS_OFFSET) >> PAGE_SHIFT, computed modulo 2^ADDR_W. The cleared low bits therefore have no effect on which entry is used.
- R3: An index at or above N_ENTRIES is a parameter error for that entry. The table is not modified. An address below BUS_OFFSET wraps to a large index and also fails.
- R4: cmd_op 0 (write) stores cmd_value at the index, sends one notice and ends with status 0 (success).
- R5: cmd_op 1 (read) returns the stored entry on get_data with status 0. On any error get_data keeps its previous value.
- R6: cmd_op 2 (fill) fails at once with no writes if the count is zero or above N_ENTRIES. Otherwise it writes cmd_value to successive pages, and the address grows by one page per step.
- R7: cmd_op 3 (list) fails at once with no fetch if the count is zero, the count is above 512, or cmd_value has any of bits [11:0] set. Entry i is read from address cmd_value + 8·i. The read port returns the byte at address a+k in mem_rdata[8k+7:8k], and the byte at the lowest address is the most significant byte of the entry.
- R8: A multi-page command stops at the first entry that fails. The final status is the status of the last entry attempted. Entries written before the failure remain.
- R9: Each notice carries inv_iova (the page-aligned bus address) and inv_xaddr (the entry with its low PAGE_SHIFT bits cleared). It also carries inv_mask = 2^PAGE_SHIFT − 1 and inv_perm = entry[1:0], where 0 = no access, 1 = read only, 2 = write only and 3 = read/write.
- R10: While inv_valid is high and inv_ready is low, inv_valid and every notice field hold steady. At most one notice is transferred per clock.
- R11: busy rises in the cycle after a command is accepted and stays high up to and including the single cycle in which done is high. cmd_valid is ignored while busy is high.
- R12: The translator read port returns the entry at xlt_index on xlt_entry one clock later.
- R13: After reset every entry reads zero, get_data and status are zero, and busy, done, inv_valid and mem_req are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command request, taken when busy is low |
| cmd_op | input | 2 | 0 write, 1 read, 2 fill, 3 list |
| cmd_win_id | input | 64 | Window identifier |
| cmd_ioba | input | ADDR_W | I/O bus address |
| cmd_value | input | ENTRY_W | Entry value, or list address for list |
| cmd_npages | input | CNT_W | Page count for fill and list |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle end-of-command pulse |
| status | output | 1 | 0 success, 1 parameter error |
| get_data | output | ENTRY_W | Entry returned by read |
| inv_valid | output | 1 | Notice available |
| inv_ready | input | 1 | Notice consumer ready |
| inv_iova | output | ADDR_W | Page-aligned bus address |
| inv_xaddr | output | ENTRY_W | Page-aligned translated address |
| inv_mask | output | ENTRY_W | Offset mask within a page |
| inv_perm | output | 2 | Access permission |
| mem_req | output | 1 | List word read request |
| mem_addr | output | ENTRY_W | List word address |
| mem_ack | input | 1 | Read data valid |
| mem_rdata | input | ENTRY_W | Read data, lowest address in low byte |
| xlt_index | input | IDX_W | Translator entry index |
| xlt_entry | output | ENTRY_W | Translator entry, one cycle later |

## Verification
A corrupted index or address register shows up in the first notice of the command: inv_iova or inv_xaddr is wrong in the very handshake cycle in which it is transferred. The bench compares every transferred notice with its own model's queue. A wrong loop counter or a wrong stop decision becomes visible when done rises, through the status, through extra or missing notices, or through entries read back later with the read command and on the translator port. Table contents that were silently damaged are exposed by a final sweep of the translator port against the model.

// File: rtl/xlt_pkg.sv
// Shared types for the translation entry table command engine.
// Assumes: command and result codes are fixed by the external interface.
package xlt_pkg;

    typedef enum logic [1:0] {
        OP_PUT  = 2'd0,
        OP_GET  = 2'd1,
        OP_FILL = 2'd2,
        OP_LIST = 2'd3
    } xlt_op_e;

    typedef enum logic {
        RES_OK       = 1'b0,
        RES_BADPARAM = 1'b1
    } xlt_res_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_CHECK,
        S_FETCH,
        S_APPLY,
        S_NOTIFY,
        S_DONE
    } xlt_state_e;

endpackage

// File: rtl/xlt_index_calc.sv
// Turns a bus address into a table index and flags whether it is in range.
// Assumes: the window starts at BUS_OFFSET and the subtraction wraps, so an
// address below the window gives a very large index.
module xlt_index_calc #(
    parameter int unsigned          ADDR_W     = 48,
    parameter int unsigned          PAGE_SHIFT = 12,
    parameter int unsigned          N_ENTRIES  = 16,
    parameter logic [ADDR_W-1:0]    BUS_OFFSET = '0,
    localparam int unsigned         IDX_W      = $clog2(N_ENTRIES)
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [IDX_W-1:0]  idx,
    output logic              in_range
);
    localparam logic [ADDR_W-1:0] PAGE_MASK = {ADDR_W{1'b1}} << PAGE_SHIFT;

    logic [ADDR_W-1:0] rel;
    logic [ADDR_W-1:0] page_no;

    // Offset of the aligned address from the window base, in pages.
    always_comb begin
        rel      = (addr & PAGE_MASK) - BUS_OFFSET;
        page_no  = rel >> PAGE_SHIFT;
        in_range = page_no < ADDR_W'(N_ENTRIES);
        idx      = page_no[IDX_W-1:0];
    end
endmodule

// File: rtl/xlt_entry_store.sv
// Entry storage with one write port, a combinational port for the engine and
// a registered port for the address translator.
// Assumes: the table is small enough to live in flops and is cleared on reset.
module xlt_entry_store #(
    parameter int unsigned N_ENTRIES = 16,
    parameter int unsigned ENTRY_W   = 64,
    localparam int unsigned IDX_W    = $clog2(N_ENTRIES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [IDX_W-1:0]   wr_idx,
    input  logic [ENTRY_W-1:0] wr_data,
    input  logic [IDX_W-1:0]   look_idx,
    output logic [ENTRY_W-1:0] look_data,
    input  logic [IDX_W-1:0]   xlt_idx,
    output logic [ENTRY_W-1:0] xlt_data
);
    logic [ENTRY_W-1:0] ent [N_ENTRIES];

    // Clear on reset, otherwise accept one write per clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < int'(N_ENTRIES); i++) begin
                ent[i] <= '0;
            end
        end else if (wr_en) begin
            ent[wr_idx] <= wr_data;
        end
    end

    // Registered read for the translator.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            xlt_data <= '0;
        end else begin
            xlt_data <= ent[xlt_idx];
        end
    end

    // Same-cycle read for the read command.
    always_comb look_data = ent[look_idx];
endmodule

// File: rtl/xlt_notice_fmt.sv
// Forms the invalidation notice fields from a bus address and an entry.
// Assumes: the low two bits of an entry encode its access permission.
module xlt_notice_fmt #(
    parameter int unsigned ADDR_W     = 48,
    parameter int unsigned ENTRY_W    = 64,
    parameter int unsigned PAGE_SHIFT = 12
) (
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [ENTRY_W-1:0] entry,
    output logic [ADDR_W-1:0]  n_iova,
    output logic [ENTRY_W-1:0] n_xaddr,
    output logic [ENTRY_W-1:0] n_mask,
    output logic [1:0]         n_perm
);
    localparam logic [ADDR_W-1:0]  A_MASK = {ADDR_W{1'b1}} << PAGE_SHIFT;
    localparam logic [ENTRY_W-1:0] E_MASK = {ENTRY_W{1'b1}} << PAGE_SHIFT;

    // Page-align both addresses and decode the permission bits.
    always_comb begin
        n_iova  = bus_addr & A_MASK;
        n_xaddr = entry & E_MASK;
        n_mask  = ~E_MASK;
        n_perm  = entry[1:0];
    end
endmodule

// File: rtl/xlt_cmd_engine.sv
// Command sequencer for one I/O window's translation entry table.
// Checks each command, walks its pages one at a time, writes entries, sends
// one invalidation notice per write and posts a status when it ends.
// Assumes: one command at a time; the list memory answers each request with
// mem_ack after any number of cycles and holds the request until then.
module xlt_cmd_engine
    import xlt_pkg::*;
#(
    parameter int unsigned       ADDR_W           = 48,
    parameter int unsigned       ENTRY_W          = 64,
    parameter int unsigned       PAGE_SHIFT       = 12,
    parameter int unsigned       N_ENTRIES        = 16,
    parameter int unsigned       CNT_W            = 16,
    parameter int unsigned       MAX_LIST         = 512,
    parameter int unsigned       LIST_ALIGN_SHIFT = 12,
    parameter logic [31:0]       WINDOW_ID        = 32'h8000_0001,
    parameter logic [ADDR_W-1:0] BUS_OFFSET       = 48'h0000_1000_0000,
    localparam int unsigned      IDX_W            = $clog2(N_ENTRIES),
    localparam int unsigned      NBYTES           = ENTRY_W / 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cmd_valid,
    input  logic [1:0]         cmd_op,
    input  logic [63:0]        cmd_win_id,
    input  logic [ADDR_W-1:0]  cmd_ioba,
    input  logic [ENTRY_W-1:0] cmd_value,
    input  logic [CNT_W-1:0]   cmd_npages,
    output logic               busy,
    output logic               done,
    output logic               status,
    output logic [ENTRY_W-1:0] get_data,
    output logic               inv_valid,
    input  logic               inv_ready,
    output logic [ADDR_W-1:0]  inv_iova,
    output logic [ENTRY_W-1:0] inv_xaddr,
    output logic [ENTRY_W-1:0] inv_mask,
    output logic [1:0]         inv_perm,
    output logic               mem_req,
    output logic [ENTRY_W-1:0] mem_addr,
    input  logic               mem_ack,
    input  logic [ENTRY_W-1:0] mem_rdata,
    input  logic [IDX_W-1:0]   xlt_index,
    output logic [ENTRY_W-1:0] xlt_entry
);
    localparam logic [ADDR_W-1:0] A_PMASK   = {ADDR_W{1'b1}} << PAGE_SHIFT;
    localparam logic [ADDR_W-1:0] PAGE_STEP = ADDR_W'(1) << PAGE_SHIFT;

    xlt_state_e         state;
    xlt_op_e            op_q;
    logic [63:0]        id_q;
    logic [ADDR_W-1:0]  ioba_q;
    logic [ENTRY_W-1:0] val_q;
    logic [ENTRY_W-1:0] entry_q;
    logic [CNT_W-1:0]   cnt_q;
    logic [CNT_W-1:0]   step_q;
    logic               status_q;
    logic [ENTRY_W-1:0] get_q;

    logic [IDX_W-1:0]   cur_idx;
    logic               cur_in_range;
    logic [ENTRY_W-1:0] look_entry;
    logic [ENTRY_W-1:0] fetched_be;
    logic               id_ok;
    logic               last_step;
    logic               tbl_wr;

    xlt_index_calc #(
        .ADDR_W    (ADDR_W),
        .PAGE_SHIFT(PAGE_SHIFT),
        .N_ENTRIES (N_ENTRIES),
        .BUS_OFFSET(BUS_OFFSET)
    ) u_index (
        .addr    (ioba_q),
        .idx     (cur_idx),
        .in_range(cur_in_range)
    );

    xlt_entry_store #(
        .N_ENTRIES(N_ENTRIES),
        .ENTRY_W  (ENTRY_W)
    ) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (tbl_wr),
        .wr_idx   (cur_idx),
        .wr_data  (entry_q),
        .look_idx (cur_idx),
        .look_data(look_entry),
        .xlt_idx  (xlt_index),
        .xlt_data (xlt_entry)
    );

    xlt_notice_fmt #(
        .ADDR_W    (ADDR_W),
        .ENTRY_W   (ENTRY_W),
        .PAGE_SHIFT(PAGE_SHIFT)
    ) u_notice (
        .bus_addr(ioba_q),
        .entry   (entry_q),
        .n_iova  (inv_iova),
        .n_xaddr (inv_xaddr),
        .n_mask  (inv_mask),
        .n_perm  (inv_perm)
    );

    // List words arrive lowest address in the low byte; reorder so that byte
    // becomes the most significant byte of the entry.
    for (genvar b = 0; b < int'(NBYTES); b++) begin : g_swap
        assign fetched_be[ENTRY_W-1-8*b -: 8] = mem_rdata[8*b +: 8];
    end

    // Command-level decodes used by the sequencer.
    always_comb begin
        id_ok     = (id_q[63:32] == 32'd0) && (id_q[31:0] == WINDOW_ID);
        last_step = (op_q == OP_PUT) || ((step_q + CNT_W'(1)) == cnt_q);
        tbl_wr    = (state == S_APPLY) && cur_in_range;
    end

    // Port-level outputs decoded from the sequencer state.
    always_comb begin
        busy      = (state != S_IDLE);
        done      = (state == S_DONE);
        inv_valid = (state == S_NOTIFY);
        mem_req   = (state == S_FETCH);
        mem_addr  = val_q + (ENTRY_W'(step_q) << 3);
        status    = status_q;
        get_data  = get_q;
    end

    // Main sequencer: accept, check, fetch, apply, notify, finish.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= S_IDLE;
            op_q     <= OP_PUT;
            id_q     <= '0;
            ioba_q   <= '0;
            val_q    <= '0;
            entry_q  <= '0;
            cnt_q    <= '0;
            step_q   <= '0;
            status_q <= RES_OK;
            get_q    <= '0;
        end else begin
            case (state)
                S_IDLE: begin
                    if (cmd_valid) begin
                        op_q   <= xlt_op_e'(cmd_op);
                        id_q   <= cmd_win_id;
                        ioba_q <= cmd_ioba & A_PMASK;
                        val_q  <= cmd_value;
                        cnt_q  <= cmd_npages;
                        step_q <= '0;
                        state  <= S_CHECK;
                    end
                end
                S_CHECK: begin
                    status_q <= RES_BADPARAM;
                    state    <= S_DONE;
                    if (id_ok) begin
                        case (op_q)
                            OP_GET: begin
                                if (cur_in_range) begin
                                    get_q    <= look_entry;
                                    status_q <= RES_OK;
                                end
                            end
                            OP_PUT: begin
                                entry_q <= val_q;
                                state   <= S_APPLY;
                            end
                            OP_FILL: begin
                                if (cnt_q != '0 && cnt_q <= CNT_W'(N_ENTRIES)) begin
                                    entry_q <= val_q;
                                    state   <= S_APPLY;
                                end
                            end
                            default: begin
                                if (cnt_q != '0 && cnt_q <= CNT_W'(MAX_LIST) &&
                                    val_q[LIST_ALIGN_SHIFT-1:0] == '0) begin
                                    state <= S_FETCH;
                                end
                            end
                        endcase
                    end
                end
                S_FETCH: begin
                    if (mem_ack) begin
                        entry_q <= fetched_be;
                        state   <= S_APPLY;
                    end
                end
                S_APPLY: begin
                    if (cur_in_range) begin
                        state <= S_NOTIFY;
                    end else begin
                        status_q <= RES_BADPARAM;
                        state    <= S_DONE;
                    end
                end
                S_NOTIFY: begin
                    if (inv_ready) begin
                        status_q <= RES_OK;
                        if (last_step) begin
                            state <= S_DONE;
                        end else begin
                            step_q <= step_q + CNT_W'(1);
                            ioba_q <= ioba_q + PAGE_STEP;
                            state  <= (op_q == OP_LIST) ? S_FETCH : S_APPLY;
                        end
                    end
                end
                default: begin
                    state <= S_IDLE;
                end
            endcase
        end
    end
endmodule

// File: rtl/xlt_cmd_engine_chk.sv
// Protocol checker for the command engine, bound to every instance.
// Assumes: it observes only top-level ports.
module xlt_cmd_engine_chk #(
    parameter int unsigned ADDR_W     = 48,
    parameter int unsigned ENTRY_W    = 64,
    parameter int unsigned PAGE_SHIFT = 12
) (
    input logic               clk,
    input logic               rst_n,
    input logic               busy,
    input logic               done,
    input logic [ENTRY_W-1:0] get_data,
    input logic               inv_valid,
    input logic               inv_ready,
    input logic [ADDR_W-1:0]  inv_iova,
    input logic [ENTRY_W-1:0] inv_xaddr,
    input logic [ENTRY_W-1:0] inv_mask,
    input logic [1:0]         inv_perm,
    input logic               mem_req,
    input logic               mem_ack,
    input logic [ENTRY_W-1:0] mem_addr
);
    // R10: a stalled notice keeps valid and all of its fields.
    p_notice_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        inv_valid && !inv_ready |=> inv_valid && $stable(inv_iova) &&
        $stable(inv_xaddr) && $stable(inv_mask) && $stable(inv_perm));

    // R9: notice addresses are page aligned and the mask covers one page.
    p_notice_aligned_r9: assert property (@(posedge clk) disable iff (!rst_n)
        inv_valid |-> (inv_iova[PAGE_SHIFT-1:0] == '0) &&
        ((inv_xaddr & inv_mask) == '0) &&
        (inv_mask[PAGE_SHIFT-1:0] == {PAGE_SHIFT{1'b1}}));

    // R11: done lies inside the busy window and lasts one cycle.
    p_done_in_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy);
    p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R11: no notice and no fetch outside a command.
    p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !inv_valid && !mem_req);

    // R7: list words are fetched on 8-byte boundaries and requests hold.
    p_fetch_aligned_r7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> mem_addr[2:0] == 3'd0);
    p_fetch_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ack |=> mem_req && $stable(mem_addr));

    // R5: the read result changes only when a command finishes.
    p_get_only_at_end_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(get_data) |-> done);
endmodule

bind xlt_cmd_engine xlt_cmd_engine_chk #(
    .ADDR_W    (ADDR_W),
    .ENTRY_W   (ENTRY_W),
    .PAGE_SHIFT(PAGE_SHIFT)
) i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .busy     (busy),
    .done     (done),
    .get_data (get_data),
    .inv_valid(inv_valid),
    .inv_ready(inv_ready),
    .inv_iova (inv_iova),
    .inv_xaddr(inv_xaddr),
    .inv_mask (inv_mask),
    .inv_perm (inv_perm),
    .mem_req  (mem_req),
    .mem_ack  (mem_ack),
    .mem_addr (mem_addr)
);

// File: tb/test_xlt_cmd_engine.sv
// Self-checking bench: a behavioural model predicts notices, status and
// read data; notices are compared in the cycle they are transferred.
module test_xlt_cmd_engine;
    localparam int          CLK_PERIOD = 10;
    localparam int          NENT       = 16;
    localparam logic [47:0] OFF        = 48'h0000_1000_0000;
    localparam logic [31:0] WID        = 32'h8000_0001;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [1:0]  cmd_op = '0;
    logic [63:0] cmd_win_id = '0;
    logic [47:0] cmd_ioba = '0;
    logic [63:0] cmd_value = '0;
    logic [15:0] cmd_npages = '0;
    logic        busy, done, status;
    logic [63:0] get_data;
    logic        inv_valid;
    logic        inv_ready = 1'b0;
    logic [47:0] inv_iova;
    logic [63:0] inv_xaddr, inv_mask;
    logic [1:0]  inv_perm;
    logic        mem_req;
    logic [63:0] mem_addr;
    logic        mem_ack = 1'b0;
    logic [63:0] mem_rdata = '0;
    logic [3:0]  xlt_index = '0;
    logic [63:0] xlt_entry;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    logic [63:0] mtbl [NENT];
    logic        exp_status;
    logic [63:0] exp_get;
    logic [47:0] q_iova [$];
    logic [63:0] q_xaddr [$];
    logic [1:0]  q_perm [$];

    logic [7:0]  lfsr = 8'hA5;
    bit          prev_stall = 1'b0;
    logic [47:0] prev_iova;
    logic [63:0] prev_xaddr;
    logic [1:0]  prev_perm;

    xlt_cmd_engine #(
        .ADDR_W(48), .ENTRY_W(64), .PAGE_SHIFT(12), .N_ENTRIES(NENT),
        .CNT_W(16), .MAX_LIST(512), .LIST_ALIGN_SHIFT(12),
        .WINDOW_ID(WID), .BUS_OFFSET(OFF)
    ) i_xlt_cmd_engine (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_win_id(cmd_win_id), .cmd_ioba(cmd_ioba), .cmd_value(cmd_value),
        .cmd_npages(cmd_npages), .busy(busy), .done(done), .status(status),
        .get_data(get_data), .inv_valid(inv_valid), .inv_ready(inv_ready),
        .inv_iova(inv_iova), .inv_xaddr(inv_xaddr), .inv_mask(inv_mask),
        .inv_perm(inv_perm), .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata), .xlt_index(xlt_index),
        .xlt_entry(xlt_entry)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic check(input bit ok, input string req,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] mem_byte(input logic [63:0] a);
        return a[7:0] ^ a[15:8] ^ 8'h3C;
    endfunction

    function automatic logic [63:0] list_word(input logic [63:0] a);
        logic [63:0] w = '0;
        for (int k = 0; k < 8; k++) w = {w[55:0], mem_byte(a + 64'(k))};
        return w;
    endfunction

    function automatic int index_of(input logic [47:0] a);
        logic [47:0] d = (a & ~48'hFFF) - OFF;
        if ((d >> 12) < 48'(NENT)) return int'(d >> 12);
        return -1;
    endfunction

    // Behavioural model of one command: fills expectations and notice queue.
    task automatic model_cmd(input int op, input logic [63:0] id,
                             input logic [47:0] ioba, input logic [63:0] val,
                             input int n);
        logic [47:0] cur;
        logic [63:0] e;
        int cnt;
        int idx;
        exp_status = 1'b1;
        if (id[63:32] != 32'd0 || id[31:0] != WID) return;
        cur = ioba & ~48'hFFF;
        if (op == 1) begin
            idx = index_of(cur);
            if (idx >= 0) begin
                exp_get = mtbl[idx];
                exp_status = 1'b0;
            end
            return;
        end
        if (op == 0) cnt = 1;
        else if (op == 2) begin
            if (n == 0 || n > NENT) return;
            cnt = n;
        end else begin
            if (n == 0 || n > 512 || val[11:0] != 12'd0) return;
            cnt = n;
        end
        for (int i = 0; i < cnt; i++) begin
            e = (op == 3) ? list_word(val + 64'(8 * i)) : val;
            idx = index_of(cur);
            if (idx < 0) begin
                exp_status = 1'b1;
                break;
            end
            mtbl[idx] = e;
            q_iova.push_back(cur);
            q_xaddr.push_back(e & ~64'hFFF);
            q_perm.push_back(e[1:0]);
            exp_status = 1'b0;
            cur = cur + 48'h1000;
        end
    endtask

    // Issue one command, optionally try to inject another while busy.
    task automatic run_cmd(input string req, input int op, input logic [63:0] id,
                           input logic [47:0] ioba, input logic [63:0] val,
                           input int n, input bit inject);
        @(negedge clk);
        while (busy) @(negedge clk);
        cmd_valid = 1'b1; cmd_op = 2'(op); cmd_win_id = id;
        cmd_ioba = ioba; cmd_value = val; cmd_npages = 16'(n);
        model_cmd(op, id, ioba, val, n);
        @(negedge clk);
        cmd_valid = 1'b0;
        if (inject) begin
            @(negedge clk);
            cmd_valid = 1'b1; cmd_op = 2'd0; cmd_win_id = {32'd0, WID};
            cmd_ioba = OFF; cmd_value = 64'hDEAD_0000_0000_0003;
            @(negedge clk);
            cmd_valid = 1'b0;
        end
        while (!done) @(negedge clk);
        check(busy, "R11 busy during done", 64'(busy), 64'd1);
        check(status == exp_status, req, 64'(status), 64'(exp_status));
        check(get_data == exp_get, "R5 read result", get_data, exp_get);
        check(q_iova.size() == 0, "R8 notices outstanding",
              64'(q_iova.size()), 64'd0);
        q_iova.delete(); q_xaddr.delete(); q_perm.delete();
    endtask

    // Ready pattern, notice comparison and stall hold, every clock.
    always @(negedge clk) begin
        if (prev_stall) begin
            check(inv_valid && inv_iova == prev_iova && inv_xaddr == prev_xaddr &&
                  inv_perm == prev_perm, "R10 stalled notice held",
                  inv_xaddr, prev_xaddr);
        end
        lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        inv_ready = lfsr[0] | lfsr[1];
        if (rst_n && inv_valid && inv_ready) begin
            if (q_iova.size() == 0) begin
                check(1'b0, "R10 unexpected notice", 64'(inv_iova), 64'd0);
            end else begin
                check(inv_iova == q_iova[0], "R9 notice address",
                      64'(inv_iova), 64'(q_iova[0]));
                check(inv_xaddr == q_xaddr[0] && inv_perm == q_perm[0] &&
                      inv_mask == 64'hFFF, "R9 notice entry",
                      inv_xaddr, q_xaddr[0]);
                void'(q_iova.pop_front()); void'(q_xaddr.pop_front());
                void'(q_perm.pop_front());
            end
        end
        prev_stall = rst_n && inv_valid && !inv_ready;
        prev_iova = inv_iova; prev_xaddr = inv_xaddr; prev_perm = inv_perm;
    end

    // List memory: answers each request one cycle later.
    always @(negedge clk) begin
        if (mem_ack) begin
            mem_ack = 1'b0;
        end else if (mem_req) begin
            for (int k = 0; k < 8; k++) mem_rdata[8*k +: 8] = mem_byte(mem_addr + 64'(k));
            mem_ack = 1'b1;
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 50000) begin
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < NENT; i++) mtbl[i] = '0;
        exp_get = '0;
        exp_status = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R13: reset state.
        check(!busy && !done && !inv_valid && !mem_req, "R13 idle after reset",
              {60'd0, busy, done, inv_valid, mem_req}, 64'd0);
        check(get_data == 64'd0 && status == 1'b0, "R13 result regs", get_data, 64'd0);
        xlt_index = 4'd7;
        @(negedge clk);
        check(xlt_entry == 64'd0, "R13 table cleared", xlt_entry, 64'd0);

        // R4, R9: single write with read/write permission.
        run_cmd("R4 write", 0, {32'd0, WID}, OFF + 48'h3000, 64'h0000_00AB_CDE0_1003, 0, 1'b0);
        // R5: read it back.
        run_cmd("R5 read", 1, {32'd0, WID}, OFF + 48'h3000, 64'd0, 0, 1'b0);
        // R2: low address bits are cleared before indexing.
        run_cmd("R2 unaligned write", 0, {32'd0, WID}, OFF + 48'h5123, 64'h0000_0012_3456_7001, 0, 1'b0);
        run_cmd("R2 unaligned read", 1, {32'd0, WID}, OFF + 48'h5FFF, 64'd0, 0, 1'b0);
        // R1: identifier errors.
        run_cmd("R1 upper id bits", 0, {32'd1, WID}, OFF + 48'h3000, 64'h1111_0002, 0, 1'b0);
        run_cmd("R1 id mismatch", 0, {32'd0, WID ^ 32'h1}, OFF + 48'h3000, 64'h2222_0002, 0, 1'b0);
        run_cmd("R1 table unchanged", 1, {32'd0, WID}, OFF + 48'h3000, 64'd0, 0, 1'b0);
        // R3: out-of-range writes.
        run_cmd("R3 past end", 0, {32'd0, WID}, OFF + 48'h10000, 64'h3333_0003, 0, 1'b0);
        run_cmd("R3 below base", 0, {32'd0, WID}, OFF - 48'h1000, 64'h4444_0003, 0, 1'b0);
        // R5: failed read keeps the previous result.
        run_cmd("R5 read error", 1, {32'd0, WID}, OFF + 48'h20000, 64'd0, 0, 1'b0);
        // R6: fill.
        run_cmd("R6 fill four", 2, {32'd0, WID}, OFF + 48'h8000, 64'h0000_0055_0000_0001, 4, 1'b0);
        run_cmd("R6 fill too long", 2, {32'd0, WID}, OFF, 64'h0000_0066_0000_0003, NENT + 1, 1'b0);
        run_cmd("R6 fill zero", 2, {32'd0, WID}, OFF, 64'h0000_0077_0000_0003, 0, 1'b0);
        // R8: fill running off the end.
        run_cmd("R8 fill overrun", 2, {32'd0, WID}, OFF + 48'hC000, 64'h0000_0088_0000_0002, 6, 1'b0);
        // R7: list writes and list rejects.
        run_cmd("R7 list three", 3, {32'd0, WID}, OFF + 48'h1000, 64'h2000, 3, 1'b0);
        run_cmd("R7 list misaligned", 3, {32'd0, WID}, OFF, 64'h2008, 2, 1'b0);
        run_cmd("R7 list too long", 3, {32'd0, WID}, OFF, 64'h3000, 513, 1'b0);
        run_cmd("R7 list zero", 3, {32'd0, WID}, OFF, 64'h3000, 0, 1'b0);
        // R8: list running off the end.
        run_cmd("R8 list overrun", 3, {32'd0, WID}, OFF, 64'h5000, 20, 1'b0);
        // R11: a write offered while busy is ignored.
        run_cmd("R11 busy list", 3, {32'd0, WID}, OFF + 48'hA000, 64'h7000, 3, 1'b1);
        run_cmd("R11 injected write dropped", 1, {32'd0, WID}, OFF, 64'd0, 0, 1'b0);
        // R12: translator port sweep against the model.
        for (int i = 0; i < NENT; i++) begin
            xlt_index = 4'(i);
            @(negedge clk);
            check(xlt_entry == mtbl[i], "R12 translator read", xlt_entry, mtbl[i]);
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule